// File: doc/BRIEF.md
# Configuration register clock-crossing bridge

This block carries a configuration register from a fast processor-write clock domain (nominally 100 MHz) into a slower consumer clock domain (nominally 62.5 MHz). It also carries a status register from the consumer domain back to the write domain. The two clocks are treated as fully asynchronous. Each direction is split into two parts. The first part is a set of independent single-bit flags, each crossing through its own two-flop synchronizer. The second part is a multi-bit field that is never sampled directly across the boundary.

For a multi-bit field, a write strobe captures the data into a holding register in the sending domain and flips a toggle level. The receiving domain synchronizes that toggle and detects its edge. On the detected edge it copies the held data into a shadow register and raises a one-cycle update pulse. The receiving side reflects its toggle back as an acknowledge. The sender shows busy until that acknowledge has returned and a minimum write spacing has passed. A strobe that arrives while busy is dropped, and a sticky overrun flag is set. Each domain has its own synchronous active-low reset. The two resets are expected to be applied together.

Top module: `cfgx_bridge`

## Requirements
- R1: While and after reset, `cfg_fld_out` equals `CFG_DEFAULT` (0xA5 by default), `sts_fld_out` equals `STS_DEFAULT` (0x3C by default), `cfg_ctl_out` and `sts_ctl_out` are zero, and `cfg_busy`, `cfg_ovr`, `sts_busy`, `sts_ovr`, `cfg_upd` and `sts_upd` are low.
- R2: A `cfg_wr` sampled high while `cfg_busy` is low is accepted. Each accepted write gives exactly one `cfg_upd` pulse, one `clk_c` cycle wide. In that same cycle `cfg_fld_out` first shows the written `cfg_fld_in` value.
- R3: `cfg_fld_out` changes only on a `clk_c` edge where `cfg_upd` is high. `sts_fld_out` changes only on a `clk_w` edge where `sts_upd` is high.
- R4: The control bits written with an accepted write appear on `cfg_ctl_out` no later than the matching `cfg_upd` pulse. Each bit crosses through its own two-flop synchronizer.
- R5: `cfg_busy` is high in the `clk_w` cycle after an accepted write. It stays high until the acknowledge has returned, so that two accepted writes are at least `MIN_GAP` (6) `clk_w` cycles apart.
- R6: A `cfg_wr` sampled while `cfg_busy` is high is dropped. It produces no `cfg_upd` pulse, leaves `cfg_fld_out` and `cfg_ctl_out` at the previous write's values, and sets `cfg_ovr`.
- R7: `cfg_ovr` and `sts_ovr` stay high once set, until their domain's reset.
- R8: A `sts_wr` sampled high while `sts_busy` is low is accepted. Each accepted status write gives exactly one single-cycle `sts_upd` pulse in `clk_w`, with `sts_fld_out` showing the written `sts_fld_in` value in that cycle.
- R9: `sts_bits_in` is registered on every `clk_c` edge, without any strobe. Each bit reaches `sts_ctl_out` through its own two-flop synchronizer in `clk_w`.
- R10: The status direction enforces the same rules in `clk_c`. `sts_busy` is high the cycle after an accepted status write, and accepted status writes are at least `MIN_GAP` cycles apart. A `sts_wr` while busy is dropped, with no pulse and no change, and sets `sts_ovr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_w | input | 1 | Processor-write domain clock |
| rst_w_n | input | 1 | Synchronous active-low reset, write domain |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_ctl_in | input | CTL_W | Independent control bits to write |
| cfg_fld_in | input | CFG_FLD_W | Multi-bit configuration field to write |
| cfg_busy | output | 1 | Configuration transfer in flight; writes are dropped |
| cfg_ovr | output | 1 | Sticky flag: a configuration write was dropped |
| sts_ctl_out | output | STS_W | Synchronized status bits in the write domain |
| sts_fld_out | output | STS_FLD_W | Status field shadow in the write domain |
| sts_upd | output | 1 | One-cycle pulse when `sts_fld_out` loads |
| clk_c | input | 1 | Consumer domain clock |
| rst_c_n | input | 1 | Synchronous active-low reset, consumer domain |
| cfg_ctl_out | output | CTL_W | Synchronized control bits in the consumer domain |
| cfg_fld_out | output | CFG_FLD_W | Configuration field shadow in the consumer domain |
| cfg_upd | output | 1 | One-cycle pulse when `cfg_fld_out` loads |
| sts_bits_in | input | STS_W | Independent status bits, sampled every cycle |
| sts_wr | input | 1 | Status field write strobe |
| sts_fld_in | input | STS_FLD_W | Multi-bit status field to write |
| sts_busy | output | 1 | Status transfer in flight; writes are dropped |
| sts_ovr | output | 1 | Sticky flag: a status write was dropped |

## Verification
The assertions rely on three assumptions about the inputs. Both domain resets are applied together, so the toggle and acknowledge levels start equal. Write strobes and data change only between edges of their own clock. Control bits are read only at or after the update pulse, never while a transfer is in flight. The stimulus meets these conditions by asserting both resets from time zero and releasing them together. It drives every input on the falling edge of its own clock. It checks control bits only at the update pulse of the same write. Apart from the deliberate overrun cases, it waits for busy to fall before each write, sweeping every field value in both directions.

// File: rtl/cfgx_pkg.sv
// Package: shared constants, types and helpers for the config-crossing bridge.
// Assumes: nothing; pure compile-time content.
package cfgx_pkg;

    // Number of flops in every synchronizer chain.
    localparam int unsigned SYNC_STAGES = 2;

    // How the independent-bit register of a lane is loaded.
    typedef enum logic {
        BITS_ON_WRITE    = 1'b0,
        BITS_EVERY_CYCLE = 1'b1
    } bits_mode_e;

    // Width of a down-counter that must hold values 0..n.
    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/cfgx_bit_sync.sv
// Module: per-bit multi-flop synchronizer.
// Does: passes each input bit through its own chain of STAGES flops.
// Assumes: every input bit comes from a flop in another domain and is an
// independent level; no relation between bits is preserved.
module cfgx_bit_sync #(
    parameter int unsigned     WIDTH   = 1,
    parameter int unsigned     STAGES  = cfgx_pkg::SYNC_STAGES,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    generate
        for (genvar b = 0; b < WIDTH; b++) begin : g_bit
            logic [STAGES-1:0] chain;

            // Shift the asynchronous bit through the synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain <= {STAGES{RST_VAL[b]}};
                end else begin
                    chain <= {chain[STAGES-2:0], d[b]};
                end
            end

            assign q[b] = chain[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/cfgx_field_src.sv
// Module: sending half of a multi-bit field crossing.
// Does: captures an accepted write into a holding register, flips a toggle
// level, and holds busy until the receiver's acknowledge toggle matches and
// MIN_GAP cycles have passed. Strobes while busy are dropped and flagged.
// Assumes: ack_tog is the receiver's registered toggle (asynchronous here).
module cfgx_field_src #(
    parameter int unsigned      WIDTH   = 8,
    parameter int unsigned      MIN_GAP = 6,
    parameter logic [WIDTH-1:0] DEFAULT = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             ack_tog,
    output logic [WIDTH-1:0] hold,
    output logic             tog,
    output logic             busy,
    output logic             ovr
);

    localparam int unsigned GW = cfgx_pkg::cnt_width(MIN_GAP);

    logic          ack_s;
    logic [GW-1:0] gap_q;
    logic          accept;

    cfgx_bit_sync #(
        .WIDTH  (1),
        .STAGES (cfgx_pkg::SYNC_STAGES),
        .RST_VAL(1'b0)
    ) u_ack_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (ack_tog),
        .q    (ack_s)
    );

    assign busy   = (ack_s != tog) || (gap_q != '0);
    assign accept = wr && !busy;

    // Capture write data only for accepted writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold <= DEFAULT;
        end else if (accept) begin
            hold <= wdata;
        end
    end

    // Flip the load toggle once per accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tog <= 1'b0;
        end else if (accept) begin
            tog <= ~tog;
        end
    end

    // Count down the minimum spacing after each accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q <= '0;
        end else if (accept) begin
            gap_q <= GW'(MIN_GAP - 1);
        end else if (gap_q != '0) begin
            gap_q <= gap_q - 1'b1;
        end
    end

    // Remember any strobe that arrived while a transfer was in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr <= 1'b0;
        end else if (wr && busy) begin
            ovr <= 1'b1;
        end
    end

endmodule

// File: rtl/cfgx_field_dst.sv
// Module: receiving half of a multi-bit field crossing.
// Does: synchronizes the sender's toggle, and on each change copies the
// sender's holding register into a shadow register while pulsing upd for
// one cycle. Its own toggle copy is returned to the sender as acknowledge.
// Assumes: src_hold is stable from the toggle flip until the ack returns.
module cfgx_field_dst #(
    parameter int unsigned      WIDTH   = 8,
    parameter logic [WIDTH-1:0] DEFAULT = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_tog,
    input  logic [WIDTH-1:0] src_hold,
    output logic [WIDTH-1:0] shadow,
    output logic             upd,
    output logic             ack_tog
);

    logic tog_s;
    logic seen_q;
    logic load;

    cfgx_bit_sync #(
        .WIDTH  (1),
        .STAGES (cfgx_pkg::SYNC_STAGES),
        .RST_VAL(1'b0)
    ) u_tog_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (src_tog),
        .q    (tog_s)
    );

    assign load    = (tog_s != seen_q);
    assign ack_tog = seen_q;

    // Track the last toggle level acted on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
        end else begin
            seen_q <= tog_s;
        end
    end

    // Load the shadow copy and pulse upd in the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow <= DEFAULT;
            upd    <= 1'b0;
        end else begin
            upd <= load;
            if (load) begin
                shadow <= src_hold;
            end
        end
    end

endmodule

// File: rtl/cfgx_lane.sv
// Module: one direction of the bridge.
// Does: carries a group of independent bits through per-bit synchronizers
// and one multi-bit field through the toggle/shadow scheme. BITS_MODE picks
// whether the bit group is loaded on accepted writes or on every cycle.
// Assumes: source and destination clocks are unrelated.
module cfgx_lane #(
    parameter int unsigned          BITS_W       = 4,
    parameter int unsigned          FLD_W        = 8,
    parameter int unsigned          MIN_GAP      = 6,
    parameter cfgx_pkg::bits_mode_e BITS_MODE    = cfgx_pkg::BITS_ON_WRITE,
    parameter logic [BITS_W-1:0]    BITS_DEFAULT = '0,
    parameter logic [FLD_W-1:0]     FLD_DEFAULT  = '0
) (
    input  logic              src_clk,
    input  logic              src_rst_n,
    input  logic              src_wr,
    input  logic [BITS_W-1:0] src_bits,
    input  logic [FLD_W-1:0]  src_fld,
    output logic              src_busy,
    output logic              src_ovr,
    input  logic              dst_clk,
    input  logic              dst_rst_n,
    output logic [BITS_W-1:0] dst_bits,
    output logic [FLD_W-1:0]  dst_fld,
    output logic              dst_upd
);

    logic [BITS_W-1:0] bits_q;
    logic [FLD_W-1:0]  hold;
    logic              tog;
    logic              ack_tog;

    generate
        if (BITS_MODE == cfgx_pkg::BITS_ON_WRITE) begin : g_bits_on_wr
            // Register the independent bits together with accepted writes.
            always_ff @(posedge src_clk) begin
                if (!src_rst_n) begin
                    bits_q <= BITS_DEFAULT;
                end else if (src_wr && !src_busy) begin
                    bits_q <= src_bits;
                end
            end
        end else begin : g_bits_every
            // Register the independent bits on every source cycle.
            always_ff @(posedge src_clk) begin
                if (!src_rst_n) begin
                    bits_q <= BITS_DEFAULT;
                end else begin
                    bits_q <= src_bits;
                end
            end
        end
    endgenerate

    cfgx_bit_sync #(
        .WIDTH  (BITS_W),
        .STAGES (cfgx_pkg::SYNC_STAGES),
        .RST_VAL(BITS_DEFAULT)
    ) u_bits_sync (
        .clk  (dst_clk),
        .rst_n(dst_rst_n),
        .d    (bits_q),
        .q    (dst_bits)
    );

    cfgx_field_src #(
        .WIDTH  (FLD_W),
        .MIN_GAP(MIN_GAP),
        .DEFAULT(FLD_DEFAULT)
    ) u_src (
        .clk    (src_clk),
        .rst_n  (src_rst_n),
        .wr     (src_wr),
        .wdata  (src_fld),
        .ack_tog(ack_tog),
        .hold   (hold),
        .tog    (tog),
        .busy   (src_busy),
        .ovr    (src_ovr)
    );

    cfgx_field_dst #(
        .WIDTH  (FLD_W),
        .DEFAULT(FLD_DEFAULT)
    ) u_dst (
        .clk     (dst_clk),
        .rst_n   (dst_rst_n),
        .src_tog (tog),
        .src_hold(hold),
        .shadow  (dst_fld),
        .upd     (dst_upd),
        .ack_tog (ack_tog)
    );

endmodule

// File: rtl/cfgx_bridge.sv
// Module: configuration/status register clock-crossing bridge (top).
// Does: forward lane from the write domain (clk_w) to the consumer domain
// (clk_c) for control bits and a config field; reverse lane for status bits
// (sampled every cycle) and a status field.
// Assumes: clk_w and clk_c are asynchronous; both resets are applied together.
module cfgx_bridge #(
    parameter int unsigned         CTL_W       = 4,
    parameter int unsigned         CFG_FLD_W   = 8,
    parameter int unsigned         STS_W       = 4,
    parameter int unsigned         STS_FLD_W   = 8,
    parameter int unsigned         MIN_GAP     = 6,
    parameter logic [CFG_FLD_W-1:0] CFG_DEFAULT = 8'hA5,
    parameter logic [STS_FLD_W-1:0] STS_DEFAULT = 8'h3C
) (
    input  logic                 clk_w,
    input  logic                 rst_w_n,
    input  logic                 cfg_wr,
    input  logic [CTL_W-1:0]     cfg_ctl_in,
    input  logic [CFG_FLD_W-1:0] cfg_fld_in,
    output logic                 cfg_busy,
    output logic                 cfg_ovr,
    output logic [STS_W-1:0]     sts_ctl_out,
    output logic [STS_FLD_W-1:0] sts_fld_out,
    output logic                 sts_upd,
    input  logic                 clk_c,
    input  logic                 rst_c_n,
    output logic [CTL_W-1:0]     cfg_ctl_out,
    output logic [CFG_FLD_W-1:0] cfg_fld_out,
    output logic                 cfg_upd,
    input  logic [STS_W-1:0]     sts_bits_in,
    input  logic                 sts_wr,
    input  logic [STS_FLD_W-1:0] sts_fld_in,
    output logic                 sts_busy,
    output logic                 sts_ovr
);

    cfgx_lane #(
        .BITS_W      (CTL_W),
        .FLD_W       (CFG_FLD_W),
        .MIN_GAP     (MIN_GAP),
        .BITS_MODE   (cfgx_pkg::BITS_ON_WRITE),
        .BITS_DEFAULT('0),
        .FLD_DEFAULT (CFG_DEFAULT)
    ) u_fwd (
        .src_clk  (clk_w),
        .src_rst_n(rst_w_n),
        .src_wr   (cfg_wr),
        .src_bits (cfg_ctl_in),
        .src_fld  (cfg_fld_in),
        .src_busy (cfg_busy),
        .src_ovr  (cfg_ovr),
        .dst_clk  (clk_c),
        .dst_rst_n(rst_c_n),
        .dst_bits (cfg_ctl_out),
        .dst_fld  (cfg_fld_out),
        .dst_upd  (cfg_upd)
    );

    cfgx_lane #(
        .BITS_W      (STS_W),
        .FLD_W       (STS_FLD_W),
        .MIN_GAP     (MIN_GAP),
        .BITS_MODE   (cfgx_pkg::BITS_EVERY_CYCLE),
        .BITS_DEFAULT('0),
        .FLD_DEFAULT (STS_DEFAULT)
    ) u_rev (
        .src_clk  (clk_c),
        .src_rst_n(rst_c_n),
        .src_wr   (sts_wr),
        .src_bits (sts_bits_in),
        .src_fld  (sts_fld_in),
        .src_busy (sts_busy),
        .src_ovr  (sts_ovr),
        .dst_clk  (clk_w),
        .dst_rst_n(rst_w_n),
        .dst_bits (sts_ctl_out),
        .dst_fld  (sts_fld_out),
        .dst_upd  (sts_upd)
    );

endmodule

// File: rtl/cfgx_bridge_chk.sv
// Module: assertion checker for cfgx_bridge, attached with bind.
// Assumes: both resets are released together; inputs change away from edges.
module cfgx_bridge_chk #(
    parameter int unsigned MIN_GAP   = 6,
    parameter int unsigned CFG_FLD_W = 8,
    parameter int unsigned STS_FLD_W = 8
) (
    input logic                 clk_w,
    input logic                 rst_w_n,
    input logic                 clk_c,
    input logic                 rst_c_n,
    input logic                 cfg_wr,
    input logic                 cfg_busy,
    input logic                 cfg_ovr,
    input logic [CFG_FLD_W-1:0] cfg_fld_out,
    input logic                 cfg_upd,
    input logic                 sts_wr,
    input logic                 sts_busy,
    input logic                 sts_ovr,
    input logic [STS_FLD_W-1:0] sts_fld_out,
    input logic                 sts_upd
);

    int unsigned w_since;
    int unsigned c_since;

    // Cycles since the last accepted config write, saturating at MIN_GAP.
    always_ff @(posedge clk_w) begin
        if (!rst_w_n) begin
            w_since <= MIN_GAP;
        end else if (cfg_wr && !cfg_busy) begin
            w_since <= 1;
        end else if (w_since < MIN_GAP) begin
            w_since <= w_since + 1;
        end
    end

    // Cycles since the last accepted status write, saturating at MIN_GAP.
    always_ff @(posedge clk_c) begin
        if (!rst_c_n) begin
            c_since <= MIN_GAP;
        end else if (sts_wr && !sts_busy) begin
            c_since <= 1;
        end else if (c_since < MIN_GAP) begin
            c_since <= c_since + 1;
        end
    end

    // R2
    cfg_upd_one_cycle_chk: assert property (@(posedge clk_c) disable iff (!rst_c_n)
        cfg_upd |=> !cfg_upd);

    // R3
    cfg_shadow_hold_chk: assert property (@(posedge clk_c) disable iff (!rst_c_n)
        !$stable(cfg_fld_out) |-> cfg_upd);

    // R3
    sts_shadow_hold_chk: assert property (@(posedge clk_w) disable iff (!rst_w_n)
        !$stable(sts_fld_out) |-> sts_upd);

    // R5
    cfg_busy_after_wr_chk: assert property (@(posedge clk_w) disable iff (!rst_w_n)
        (cfg_wr && !cfg_busy) |=> cfg_busy);

    // R5
    cfg_min_gap_chk: assert property (@(posedge clk_w) disable iff (!rst_w_n)
        (cfg_wr && !cfg_busy) |-> (w_since >= MIN_GAP));

    // R6
    cfg_overrun_set_chk: assert property (@(posedge clk_w) disable iff (!rst_w_n)
        (cfg_wr && cfg_busy) |=> cfg_ovr);

    // R7
    cfg_overrun_sticky_chk: assert property (@(posedge clk_w) disable iff (!rst_w_n)
        cfg_ovr |=> cfg_ovr);

    // R7
    sts_overrun_sticky_chk: assert property (@(posedge clk_c) disable iff (!rst_c_n)
        sts_ovr |=> sts_ovr);

    // R8
    sts_upd_one_cycle_chk: assert property (@(posedge clk_w) disable iff (!rst_w_n)
        sts_upd |=> !sts_upd);

    // R10
    sts_busy_after_wr_chk: assert property (@(posedge clk_c) disable iff (!rst_c_n)
        (sts_wr && !sts_busy) |=> sts_busy);

    // R10
    sts_min_gap_chk: assert property (@(posedge clk_c) disable iff (!rst_c_n)
        (sts_wr && !sts_busy) |-> (c_since >= MIN_GAP));

    // R10
    sts_overrun_set_chk: assert property (@(posedge clk_c) disable iff (!rst_c_n)
        (sts_wr && sts_busy) |=> sts_ovr);

endmodule

bind cfgx_bridge cfgx_bridge_chk #(
    .MIN_GAP  (MIN_GAP),
    .CFG_FLD_W(CFG_FLD_W),
    .STS_FLD_W(STS_FLD_W)
) u_chk (
    .clk_w      (clk_w),
    .rst_w_n    (rst_w_n),
    .clk_c      (clk_c),
    .rst_c_n    (rst_c_n),
    .cfg_wr     (cfg_wr),
    .cfg_busy   (cfg_busy),
    .cfg_ovr    (cfg_ovr),
    .cfg_fld_out(cfg_fld_out),
    .cfg_upd    (cfg_upd),
    .sts_wr     (sts_wr),
    .sts_busy   (sts_busy),
    .sts_ovr    (sts_ovr),
    .sts_fld_out(sts_fld_out),
    .sts_upd    (sts_upd)
);

// File: tb/cfgx_bridge_bench.sv
`timescale 1ns/1ps
// Bench: sweeps every field value in both directions, every status-bit
// pattern, overrun cases and a second reset; expected values come from the
// requirements.
module cfgx_bridge_bench;

    localparam int CLK_W_NS = 10;
    localparam int CLK_C_NS = 16;
    localparam int MIN_GAP  = 6;
    localparam logic [7:0] CFG_DEF = 8'hA5;
    localparam logic [7:0] STS_DEF = 8'h3C;

    logic clk_w = 1'b0;
    logic clk_c = 1'b0;
    logic rst_w_n = 1'b0;
    logic rst_c_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [3:0] cfg_ctl_in = '0;
    logic [7:0] cfg_fld_in = '0;
    logic       cfg_busy, cfg_ovr, sts_upd, cfg_upd, sts_busy, sts_ovr;
    logic [3:0] sts_ctl_out, cfg_ctl_out;
    logic [7:0] sts_fld_out, cfg_fld_out;
    logic [3:0] sts_bits_in = '0;
    logic       sts_wr = 1'b0;
    logic [7:0] sts_fld_in = '0;

    int n_cmp = 0;
    int n_bad = 0;
    int n_cfg_upd = 0;
    int n_sts_upd = 0;
    bit finished = 1'b0;

    always #(CLK_W_NS / 2) clk_w = ~clk_w;
    always #(CLK_C_NS / 2) clk_c = ~clk_c;

    cfgx_bridge u_cfgx_bridge (
        .clk_w(clk_w), .rst_w_n(rst_w_n), .cfg_wr(cfg_wr),
        .cfg_ctl_in(cfg_ctl_in), .cfg_fld_in(cfg_fld_in),
        .cfg_busy(cfg_busy), .cfg_ovr(cfg_ovr),
        .sts_ctl_out(sts_ctl_out), .sts_fld_out(sts_fld_out), .sts_upd(sts_upd),
        .clk_c(clk_c), .rst_c_n(rst_c_n),
        .cfg_ctl_out(cfg_ctl_out), .cfg_fld_out(cfg_fld_out), .cfg_upd(cfg_upd),
        .sts_bits_in(sts_bits_in), .sts_wr(sts_wr), .sts_fld_in(sts_fld_in),
        .sts_busy(sts_busy), .sts_ovr(sts_ovr)
    );

    always @(negedge clk_c) if (rst_c_n && cfg_upd) n_cfg_upd++;
    always @(negedge clk_w) if (rst_w_n && sts_upd) n_sts_upd++;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_reset_state();
        check("R1 cfg_fld_out", cfg_fld_out, CFG_DEF);
        check("R1 sts_fld_out", sts_fld_out, STS_DEF);
        check("R1 cfg_ctl_out", cfg_ctl_out, 0);
        check("R1 sts_ctl_out", sts_ctl_out, 0);
        check("R1 flags", {cfg_busy, cfg_ovr, sts_busy, sts_ovr, cfg_upd, sts_upd}, 0);
    endtask

    task automatic do_reset();
        @(negedge clk_w);
        rst_w_n = 1'b0;
        rst_c_n = 1'b0;
        repeat (4) @(negedge clk_c);
        check_reset_state();
        @(negedge clk_w);
        rst_w_n = 1'b1;
        rst_c_n = 1'b1;
        repeat (3) @(negedge clk_c);
        @(negedge clk_w);
        check_reset_state();
    endtask

    // Forward transfer: R2, R4, R5.
    task automatic cfg_xfer(input logic [3:0] c, input logic [7:0] f);
        realtime t0;
        bit got;
        @(negedge clk_w);
        while (cfg_busy) @(negedge clk_w);
        cfg_ctl_in = c;
        cfg_fld_in = f;
        cfg_wr     = 1'b1;
        t0         = $realtime;
        @(negedge clk_w);
        cfg_wr = 1'b0;
        check("R5 busy after write", cfg_busy, 1);
        got = 1'b0;
        for (int i = 0; i < 40 && !got; i++) begin
            @(negedge clk_c);
            if (cfg_upd) got = 1'b1;
        end
        check("R2 pulse seen", got, 1);
        check("R2 field value", cfg_fld_out, f);
        check("R4 control bits", cfg_ctl_out, c);
        @(negedge clk_c);
        check("R2 pulse one cycle", cfg_upd, 0);
        @(negedge clk_w);
        while (cfg_busy) @(negedge clk_w);
        check("R5 spacing", ($realtime - t0) >= (MIN_GAP * CLK_W_NS), 1);
    endtask

    // Reverse transfer: R8, R10.
    task automatic sts_xfer(input logic [7:0] f);
        realtime t0;
        bit got;
        @(negedge clk_c);
        while (sts_busy) @(negedge clk_c);
        sts_fld_in = f;
        sts_wr     = 1'b1;
        t0         = $realtime;
        @(negedge clk_c);
        sts_wr = 1'b0;
        check("R10 busy after write", sts_busy, 1);
        got = 1'b0;
        for (int i = 0; i < 60 && !got; i++) begin
            @(negedge clk_w);
            if (sts_upd) got = 1'b1;
        end
        check("R8 pulse seen", got, 1);
        check("R8 field value", sts_fld_out, f);
        @(negedge clk_w);
        check("R8 pulse one cycle", sts_upd, 0);
        @(negedge clk_c);
        while (sts_busy) @(negedge clk_c);
        check("R10 spacing", ($realtime - t0) >= (MIN_GAP * CLK_C_NS), 1);
    endtask

    initial begin
        int base;
        do_reset();

        // R2 R4 R5: sweep every field value forward.
        base = n_cfg_upd;
        for (int v = 0; v < 256; v++) begin
            cfg_xfer(4'(v[3:0] ^ v[7:4]), 8'(v));
        end
        repeat (10) @(negedge clk_c);
        check("R2 one pulse per write", n_cfg_upd - base, 256);

        // R8 R10: sweep every field value backward.
        base = n_sts_upd;
        for (int v = 0; v < 256; v++) begin
            sts_xfer(8'(255 - v));
        end
        repeat (10) @(negedge clk_w);
        check("R8 one pulse per write", n_sts_upd - base, 256);

        // R9: every status bit pattern, no strobe.
        for (int v = 0; v < 16; v++) begin
            @(negedge clk_c);
            sts_bits_in = 4'(v);
            repeat (4) @(negedge clk_c);
            @(negedge clk_w);
            check("R9 status bits", sts_ctl_out, v);
        end

        // R6 R7: forward overrun.
        @(negedge clk_w);
        while (cfg_busy) @(negedge clk_w);
        base = n_cfg_upd;
        cfg_ctl_in = 4'h5; cfg_fld_in = 8'h5A; cfg_wr = 1'b1;
        @(negedge clk_w);
        cfg_ctl_in = 4'hA; cfg_fld_in = 8'hC3;
        @(negedge clk_w);
        cfg_wr = 1'b0;
        check("R6 overrun flag", cfg_ovr, 1);
        repeat (40) @(negedge clk_c);
        check("R6 dropped write no pulse", n_cfg_upd - base, 1);
        check("R6 field kept", cfg_fld_out, 8'h5A);
        check("R6 control kept", cfg_ctl_out, 4'h5);
        cfg_xfer(4'h3, 8'h77);
        check("R7 overrun sticky", cfg_ovr, 1);

        // R10 R7: reverse overrun.
        @(negedge clk_c);
        while (sts_busy) @(negedge clk_c);
        base = n_sts_upd;
        sts_fld_in = 8'h96; sts_wr = 1'b1;
        @(negedge clk_c);
        sts_fld_in = 8'h69;
        @(negedge clk_c);
        sts_wr = 1'b0;
        check("R10 overrun flag", sts_ovr, 1);
        repeat (60) @(negedge clk_w);
        check("R10 dropped write no pulse", n_sts_upd - base, 1);
        check("R10 field kept", sts_fld_out, 8'h96);
        sts_xfer(8'h11);
        check("R7 status overrun sticky", sts_ovr, 1);

        // R1 R7: reset clears overrun and restores defaults.
        sts_bits_in = '0;
        do_reset();

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(CLK_W_NS * 150000);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule